// File: doc/BRIEF.md
# Dual-Clock Cycle-Ratio Counter

This block compares two free-running, mutually asynchronous clocks. A host programs a goal: a number of reference-clock (domain A) cycles. It then issues a start and the block counts the cycles of the measured clock (domain B) that pass while the goal elapses. When the reference count expires, the measured counter is frozen. The frozen value is handed back to the bus domain through a request/acknowledge exchange, and only then is completion flagged. The ratio of the two counts gives the frequency ratio of the clocks.

The register interface is a Wishbone classic slave clocked by `clk_a`. Every crossing uses a two-flop toggle synchronizer: the launch and the halt go from A to B, the result request goes from B to A, and the acknowledge goes from A to B. The measured counter is enabled only once the synchronized launch arrives, and the halt is delayed the same way. The reported count therefore carries a small bias: about one B cycle low, with a quantization of one B cycle.

The reference side is a state machine with three states. IDLE moves to RUN on an accepted start with a nonzero goal. RUN moves to COLLECT when the goal expires. COLLECT moves back to IDLE when the result request arrives. The measured side is also a state machine with three states. IDLE moves to COUNT on the launch. COUNT moves to HOLD on the halt. HOLD moves back to COUNT on a new launch, or to IDLE on the acknowledge.

Top module: `cycle_ratio_meter`

## Requirements
- R1: After reset, the words at offsets 0x0, 0x4, 0x8 and 0xC all read as zero.
- R2: The goal register at 0x8 holds a full 32-bit value that is written and read back. The control word at 0x0 reads zero at all times, because its start bit (bit 0) clears itself. Each bus access receives an acknowledge lasting one cycle.
- R3: A write of 1 to bit 0 at 0x0 with a nonzero goal starts a run. During the run, the status word at 0x4 reads 0x2 (bit 1 busy set, bit 0 done clear, bit 2 overflow clear).
- R4: With goal G, the result at 0xC lies in [floor(G·Ta/Tb)−2, floor(G·Ta/Tb)+1], where Ta and Tb are the periods of the A and B clocks.
- R5: Done (status bit 0) rises only after the frozen B count has been captured in the bus domain, and busy clears at the same time. While the measured side is frozen, its count does not change, and repeated reads of 0xC return the same value.
- R6: A start written while a run is in progress is ignored, and the run keeps its original start point.
- R7: The goal is latched when a run starts, so a write to 0x8 during a run does not change that run's length.
- R8: A start with a goal of zero completes at once: status reads 0x1 and the result reads 0.
- R9: The B counter saturates at 2^B_CNT_W−1 and sets status bit 2. The next start clears bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Reference clock; also clocks the bus |
| rst_a_n | input | 1 | Asynchronous active-low reset, domain A |
| clk_b | input | 1 | Measured clock |
| rst_b_n | input | 1 | Asynchronous active-low reset, domain B |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 4 | Byte address; bits 3:2 select the word |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Access acknowledge |

## Verification
A stuck reference state shows at the ports in two ways. A machine that never leaves COLLECT keeps busy set indefinitely, so the polling loop times out within a few thousand cycles. A machine that leaves RUN at the wrong count shifts the result outside the R4 window at the first run. A measured counter that keeps counting after the halt, or a lost launch or halt event, shows up as a result far outside the window or as a second read differing from the first. A stale overflow flag or a mishandled zero goal shows in the very next status read.

// File: rtl/crm_pkg.sv
`timescale 1ns/1ps
package crm_pkg;
    localparam int WB_DW = 32;
    localparam int WB_AW = 4;

    localparam logic [1:0] WORD_CTRL = 2'd0;
    localparam logic [1:0] WORD_STAT = 2'd1;
    localparam logic [1:0] WORD_GOAL = 2'd2;
    localparam logic [1:0] WORD_RES  = 2'd3;

    localparam int STAT_DONE = 0;
    localparam int STAT_BUSY = 1;
    localparam int STAT_OVF  = 2;

    typedef enum logic [1:0] {
        A_IDLE    = 2'd0,
        A_RUN     = 2'd1,
        A_COLLECT = 2'd2
    } ref_state_t;

    typedef enum logic [1:0] {
        B_IDLE  = 2'd0,
        B_COUNT = 2'd1,
        B_HOLD  = 2'd2
    } meas_state_t;
endpackage

// File: rtl/crm_toggle_sync.sv
`timescale 1ns/1ps
module crm_toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    logic              src_tgl;
    logic [STAGES-1:0] chain;
    logic              last;

    // source side: each event flips a level
    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n)     src_tgl <= 1'b0;
        else if (src_pulse) src_tgl <= ~src_tgl;
    end

    // destination side: resynchronize the level, then detect its edges
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge dst_clk or negedge dst_rst_n) begin
                if (!dst_rst_n) chain <= '0;
                else            chain <= src_tgl;
            end
        end else begin : g_many
            always_ff @(posedge dst_clk or negedge dst_rst_n) begin
                if (!dst_rst_n) chain <= '0;
                else            chain <= {chain[STAGES-2:0], src_tgl};
            end
        end
    endgenerate

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) last <= 1'b0;
        else            last <= chain[STAGES-1];
    end

    assign dst_pulse = chain[STAGES-1] ^ last;
endmodule

// File: rtl/crm_wb_regs.sv
`timescale 1ns/1ps
module crm_wb_regs
    import crm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wb_cyc,
    input  logic             wb_stb,
    input  logic             wb_we,
    input  logic [WB_AW-1:0] wb_adr,
    input  logic [WB_DW-1:0] wb_dat_i,
    output logic [WB_DW-1:0] wb_dat_o,
    output logic             wb_ack,
    output logic             start_req,
    output logic [WB_DW-1:0] cfg_target,
    input  logic             stat_done,
    input  logic             stat_busy,
    input  logic             stat_ovf,
    input  logic [WB_DW-1:0] res_count
);
    logic       access;
    logic       aligned;
    logic [1:0] word;
    logic [WB_DW-1:0] rd_mux;

    assign access  = wb_cyc & wb_stb & ~wb_ack;
    assign aligned = (wb_adr[1:0] == 2'b00);
    assign word    = wb_adr[3:2];

    assign start_req = access & wb_we & aligned & (word == WORD_CTRL) & wb_dat_i[0];

    always_comb begin
        rd_mux = '0;
        if (aligned) begin
            unique case (word)
                WORD_CTRL: rd_mux = '0;
                WORD_STAT: begin
                    rd_mux[STAT_DONE] = stat_done;
                    rd_mux[STAT_BUSY] = stat_busy;
                    rd_mux[STAT_OVF]  = stat_ovf;
                end
                WORD_GOAL: rd_mux = cfg_target;
                WORD_RES:  rd_mux = res_count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_ack     <= 1'b0;
            wb_dat_o   <= '0;
            cfg_target <= '0;
        end else begin
            wb_ack <= access;
            if (access && !wb_we) wb_dat_o <= rd_mux;
            if (access && wb_we && aligned && word == WORD_GOAL) cfg_target <= wb_dat_i;
        end
    end
endmodule

// File: rtl/crm_ref_ctrl.sv
`timescale 1ns/1ps
module crm_ref_ctrl
    import crm_pkg::*;
#(
    parameter int B_CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_req,
    input  logic [WB_DW-1:0]   cfg_target,
    input  logic               res_pulse,
    input  logic [B_CNT_W-1:0] b_count,
    input  logic               b_ovf,
    output logic               busy,
    output logic               done,
    output logic               ovf,
    output logic [WB_DW-1:0]   result,
    output logic               launch,
    output logic               halt,
    output logic               ack_back
);
    ref_state_t       state_q, state_d;
    logic [WB_DW-1:0] goal;
    logic [WB_DW-1:0] a_cnt;
    logic             zero_go;

    assign zero_go  = (state_q == A_IDLE) && start_req && (cfg_target == '0);
    assign launch   = (state_q == A_IDLE) && start_req && (cfg_target != '0);
    assign halt     = (state_q == A_RUN) && (a_cnt == goal - WB_DW'(1));
    assign ack_back = (state_q == A_COLLECT) && res_pulse;
    assign busy     = (state_q != A_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= A_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            A_IDLE:    if (launch)   state_d = A_RUN;
            A_RUN:     if (halt)     state_d = A_COLLECT;
            A_COLLECT: if (ack_back) state_d = A_IDLE;
            default:                 state_d = A_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            goal   <= '0;
            a_cnt  <= '0;
            done   <= 1'b0;
            ovf    <= 1'b0;
            result <= '0;
        end else begin
            if (launch) begin
                goal  <= cfg_target;
                a_cnt <= '0;
                done  <= 1'b0;
                ovf   <= 1'b0;
            end else if (zero_go) begin
                done   <= 1'b1;
                ovf    <= 1'b0;
                result <= '0;
            end else if (state_q == A_RUN) begin
                a_cnt <= a_cnt + WB_DW'(1);
            end else if (ack_back) begin
                result <= WB_DW'(b_count);
                ovf    <= b_ovf;
                done   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/crm_meas_cnt.sv
`timescale 1ns/1ps
module crm_meas_cnt
    import crm_pkg::*;
#(
    parameter int B_CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic               halt,
    input  logic               ack,
    output logic [B_CNT_W-1:0] count,
    output logic               ovf,
    output logic               frozen,
    output logic               req
);
    localparam logic [B_CNT_W-1:0] CNT_MAX = '1;

    meas_state_t state_q, state_d;
    logic        restart;

    assign restart = go && (state_q != B_COUNT);
    assign req     = (state_q == B_COUNT) && halt;
    assign frozen  = (state_q == B_HOLD);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= B_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            B_IDLE:  if (go)   state_d = B_COUNT;
            B_COUNT: if (halt) state_d = B_HOLD;
            B_HOLD: begin
                if (go)       state_d = B_COUNT;
                else if (ack) state_d = B_IDLE;
            end
            default:          state_d = B_IDLE;
        endcase
    end

    // counter with saturation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (restart) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (state_q == B_COUNT && !halt) begin
            if (count == CNT_MAX) ovf   <= 1'b1;
            else                  count <= count + B_CNT_W'(1);
        end
    end
endmodule

// File: rtl/cycle_ratio_meter.sv
`timescale 1ns/1ps
module cycle_ratio_meter
    import crm_pkg::*;
#(
    parameter int B_CNT_W     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_a,
    input  logic             rst_a_n,
    input  logic             clk_b,
    input  logic             rst_b_n,
    input  logic             wb_cyc_i,
    input  logic             wb_stb_i,
    input  logic             wb_we_i,
    input  logic [WB_AW-1:0] wb_adr_i,
    input  logic [WB_DW-1:0] wb_dat_i,
    output logic [WB_DW-1:0] wb_dat_o,
    output logic             wb_ack_o
);
    logic               a_start_req;
    logic [WB_DW-1:0]   cfg_target;
    logic               a_busy, a_done, a_ovf;
    logic [WB_DW-1:0]   a_result;
    logic               a_launch, a_halt, a_ack, a_res_pulse;
    logic               b_go, b_halt, b_ack, b_req;
    logic [B_CNT_W-1:0] b_count;
    logic               b_ovf, b_frozen;

    crm_wb_regs u_regs (
        .clk        (clk_a),
        .rst_n      (rst_a_n),
        .wb_cyc     (wb_cyc_i),
        .wb_stb     (wb_stb_i),
        .wb_we      (wb_we_i),
        .wb_adr     (wb_adr_i),
        .wb_dat_i   (wb_dat_i),
        .wb_dat_o   (wb_dat_o),
        .wb_ack     (wb_ack_o),
        .start_req  (a_start_req),
        .cfg_target (cfg_target),
        .stat_done  (a_done),
        .stat_busy  (a_busy),
        .stat_ovf   (a_ovf),
        .res_count  (a_result)
    );

    crm_ref_ctrl #(.B_CNT_W(B_CNT_W)) u_ref (
        .clk        (clk_a),
        .rst_n      (rst_a_n),
        .start_req  (a_start_req),
        .cfg_target (cfg_target),
        .res_pulse  (a_res_pulse),
        .b_count    (b_count),
        .b_ovf      (b_ovf),
        .busy       (a_busy),
        .done       (a_done),
        .ovf        (a_ovf),
        .result     (a_result),
        .launch     (a_launch),
        .halt       (a_halt),
        .ack_back   (a_ack)
    );

    crm_meas_cnt #(.B_CNT_W(B_CNT_W)) u_meas (
        .clk    (clk_b),
        .rst_n  (rst_b_n),
        .go     (b_go),
        .halt   (b_halt),
        .ack    (b_ack),
        .count  (b_count),
        .ovf    (b_ovf),
        .frozen (b_frozen),
        .req    (b_req)
    );

    crm_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync_go (
        .src_clk (clk_a), .src_rst_n (rst_a_n), .src_pulse (a_launch),
        .dst_clk (clk_b), .dst_rst_n (rst_b_n), .dst_pulse (b_go)
    );

    crm_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync_halt (
        .src_clk (clk_a), .src_rst_n (rst_a_n), .src_pulse (a_halt),
        .dst_clk (clk_b), .dst_rst_n (rst_b_n), .dst_pulse (b_halt)
    );

    crm_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync_req (
        .src_clk (clk_b), .src_rst_n (rst_b_n), .src_pulse (b_req),
        .dst_clk (clk_a), .dst_rst_n (rst_a_n), .dst_pulse (a_res_pulse)
    );

    crm_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
        .src_clk (clk_a), .src_rst_n (rst_a_n), .src_pulse (a_ack),
        .dst_clk (clk_b), .dst_rst_n (rst_b_n), .dst_pulse (b_ack)
    );
endmodule

// File: rtl/crm_checker.sv
`timescale 1ns/1ps
module crm_checker #(
    parameter int B_CNT_W = 32
) (
    input logic               clk_a,
    input logic               rst_a_n,
    input logic               clk_b,
    input logic               rst_b_n,
    input logic               wb_ack_o,
    input logic               a_start_req,
    input logic               a_busy,
    input logic               a_done,
    input logic [31:0]        cfg_target,
    input logic [B_CNT_W-1:0] b_count,
    input logic               b_frozen,
    input logic               b_go
);
    localparam logic [B_CNT_W-1:0] CNT_MAX = '1;

    a_r2_single_ack: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        wb_ack_o |=> !wb_ack_o);

    a_r5_done_not_busy: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        a_done |-> !a_busy);

    a_r8_zero_goal: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (a_start_req && !a_busy && cfg_target == 32'd0) |=> (a_done && !a_busy));

    a_r5_frozen_stable: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (b_frozen && !b_go) |=> $stable(b_count));

    a_r9_sat_hold: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (b_count == CNT_MAX && !b_go) |=> (b_count == CNT_MAX));
endmodule

bind cycle_ratio_meter crm_checker #(.B_CNT_W(B_CNT_W)) u_chk (
    .clk_a       (clk_a),
    .rst_a_n     (rst_a_n),
    .clk_b       (clk_b),
    .rst_b_n     (rst_b_n),
    .wb_ack_o    (wb_ack_o),
    .a_start_req (a_start_req),
    .a_busy      (a_busy),
    .a_done      (a_done),
    .cfg_target  (cfg_target),
    .b_count     (b_count),
    .b_frozen    (b_frozen),
    .b_go        (b_go)
);

// File: tb/sim_cycle_ratio_meter.sv
`timescale 1ns/100ps
module sim_cycle_ratio_meter;
    localparam int    BW    = 10;
    localparam longint TA_PS = 10000;
    localparam longint TB_PS = 7000;
    localparam int    NVEC  = 6;
    localparam int unsigned VEC_GOAL [NVEC] = '{1, 2, 5, 17, 100, 333};
    localparam logic [31:0] VEC_STAT [NVEC] = '{32'h1, 32'h1, 32'h1, 32'h1, 32'h1, 32'h1};

    logic        clk_a, clk_b, rst_a_n, rst_b_n;
    logic        wb_cyc, wb_stb, wb_we, wb_ack;
    logic [3:0]  wb_adr;
    logic [31:0] wb_wdat, wb_rdat;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    cycle_ratio_meter #(.B_CNT_W(BW)) u0 (
        .clk_a (clk_a), .rst_a_n (rst_a_n), .clk_b (clk_b), .rst_b_n (rst_b_n),
        .wb_cyc_i (wb_cyc), .wb_stb_i (wb_stb), .wb_we_i (wb_we),
        .wb_adr_i (wb_adr), .wb_dat_i (wb_wdat), .wb_dat_o (wb_rdat), .wb_ack_o (wb_ack)
    );

    initial clk_a = 1'b0;
    always #5 clk_a = ~clk_a;
    initial begin
        clk_b = 1'b0;
        #1.3;
        forever #3.5 clk_b = ~clk_b;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wb_write(input logic [3:0] adr, input logic [31:0] data);
        @(negedge clk_a);
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b1; wb_adr = adr; wb_wdat = data;
        do begin @(posedge clk_a); #1; end while (!wb_ack);
        @(negedge clk_a);
        wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
    endtask

    task automatic wb_read(input logic [3:0] adr, output logic [31:0] data);
        @(negedge clk_a);
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b0; wb_adr = adr;
        do begin @(posedge clk_a); #1; end while (!wb_ack);
        data = wb_rdat;
        @(negedge clk_a);
        wb_cyc = 1'b0; wb_stb = 1'b0;
    endtask

    task automatic wait_done(output logic [31:0] st);
        st = '0;
        for (int i = 0; i < 3000; i++) begin
            wb_read(4'h4, st);
            if (st[0]) break;
        end
    endtask

    task automatic check_window(input string tag, input int unsigned goal, input logic [31:0] res);
        longint ideal;
        ideal = (longint'(goal) * TA_PS) / TB_PS;
        check((longint'(res) >= ideal - 2) && (longint'(res) <= ideal + 1), tag, longint'(res), ideal);
    endtask

    initial begin
        repeat (150000) @(posedge clk_a);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, rd2, st;
        wb_cyc = 0; wb_stb = 0; wb_we = 0; wb_adr = '0; wb_wdat = '0;
        rst_a_n = 0; rst_b_n = 0;
        repeat (4) @(posedge clk_a);
        rst_a_n = 1; rst_b_n = 1;
        repeat (2) @(posedge clk_a);

        // R1: reset values
        wb_read(4'h0, rd); check(rd == 0, "R1 ctrl", rd, 0);
        wb_read(4'h4, rd); check(rd == 0, "R1 status", rd, 0);
        wb_read(4'h8, rd); check(rd == 0, "R1 goal", rd, 0);
        wb_read(4'hC, rd); check(rd == 0, "R1 result", rd, 0);

        // R2: goal register width, self-clearing control
        wb_write(4'h8, 32'hA5A5_1234);
        wb_read(4'h8, rd); check(rd == 32'hA5A5_1234, "R2 goal readback", rd, 32'hA5A5_1234);

        // table of runs: R3, R4, R5
        for (int v = 0; v < NVEC; v++) begin
            wb_write(4'h8, VEC_GOAL[v]);
            wb_write(4'h0, 32'h1);
            wb_read(4'h4, st); check(st == 32'h2, "R3 busy during run", st, 2);
            wb_read(4'h0, rd); check(rd == 0, "R2 control self-clears", rd, 0);
            wait_done(st);
            check(st == VEC_STAT[v], "R5 done status", st, VEC_STAT[v]);
            wb_read(4'hC, rd);
            check_window("R4 result window", VEC_GOAL[v], rd);
            wb_read(4'hC, rd2); check(rd2 == rd, "R5 result stable", rd2, rd);
        end

        // R6: start during a run is ignored
        wb_write(4'h8, 32'd200);
        wb_write(4'h0, 32'h1);
        repeat (50) @(posedge clk_a);
        wb_write(4'h0, 32'h1);
        wb_read(4'h4, st); check(st == 32'h2, "R6 still busy", st, 2);
        wait_done(st);
        wb_read(4'hC, rd);
        check_window("R6 original start kept", 200, rd);

        // R7: goal latched at start
        wb_write(4'h8, 32'd300);
        wb_write(4'h0, 32'h1);
        wb_write(4'h8, 32'd20);
        wait_done(st);
        wb_read(4'hC, rd);
        check_window("R7 goal latched", 300, rd);
        wb_read(4'h8, rd); check(rd == 20, "R7 goal readback", rd, 20);

        // R9: saturation and overflow flag
        wb_write(4'h8, 32'd800);
        wb_write(4'h0, 32'h1);
        wait_done(st);
        check(st == 32'h5, "R9 overflow status", st, 5);
        wb_read(4'hC, rd); check(rd == 32'd1023, "R9 saturated count", rd, 1023);

        // R8: zero goal completes at once and clears overflow
        wb_write(4'h8, 32'd0);
        wb_write(4'h0, 32'h1);
        wb_read(4'h4, st); check(st == 32'h1, "R8 zero goal status", st, 1);
        wb_read(4'hC, rd); check(rd == 0, "R8 zero goal result", rd, 0);

        // R9: overflow cleared by the next normal run
        wb_write(4'h8, 32'd800);
        wb_write(4'h0, 32'h1);
        wait_done(st);
        wb_write(4'h8, 32'd5);
        wb_write(4'h0, 32'h1);
        wait_done(st);
        check(st == 32'h1, "R9 overflow cleared", st, 1);
        wb_read(4'hC, rd);
        check_window("R4 after overflow run", 5, rd);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule